// File: doc/BRIEF.md
# Two-Bank Indexed CMOS Memory Port

This block presents a byte-wide battery-backed memory through four byte ports selected by a 2-bit port number. Ports 0 and 1 form the first index/data pair: a write to port 0 sets the first bank's index, and reads or writes on port 1 move a byte at that index. Ports 2 and 3 form the second pair and do the same for the second bank. Each transfer is therefore an index write followed by one or more data transfers.

The second bank is plain RAM over its whole 128-byte range. The first bank is shared: its lowest fourteen indexes (0x00 to 0x0D) do not reach RAM but are forwarded to an external clock register file through a small register-side interface. Indexes 0x0E to 0x7F of the first bank are general-purpose RAM. The optional alarm-day, alarm-month and century locations some systems define fall in this RAM area. The clock registers themselves, and any checksum over RAM contents, are outside this block.

Data-port reads are combinational from the latched index and the port number. Writes take effect on the rising clock edge of a cycle in which the access strobe is high.

Top module: `cmos_bank_port`

## Requirements
- R1: After reset both bank indexes are 0, so a port-1 access targets clock register 0 (clkRegAddr reads 0).
- R2: A strobed write to port 0 (port 2) loads bits 6:0 of the write byte into the first (second) bank index; bit 7 is discarded.
- R3: With the first-bank index below 14, a strobed port-1 write pulses clkRegWe for that cycle with clkRegAddr equal to the index and clkRegWdata equal to the byte, and a port-1 read returns clkRegRdata.
- R4: With the first-bank index from 14 to 127, a strobed port-1 write stores the byte in first-bank RAM on the clock edge, and a later port-1 read returns it.
- R5: Ports 3 access a separate 128-byte second-bank RAM at every index 0 to 127; its writes never alter first-bank RAM or the clock registers.
- R6: An index keeps its value across data transfers, so repeated port-1 or port-3 accesses hit the same byte, the last write winning.
- R7: Reads of the index ports 0 and 2 return 0x00.
- R8: clkRegWe and clkRegRd are asserted only for strobed port-1 writes and reads, respectively, whose first-bank index is below 14; clkRegRd marks a strobed port-1 read of a clock register.
- R9: With the access strobe low, no index, RAM byte or clock register changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busEn | input | 1 | Access strobe for the current cycle |
| busAddr | input | 2 | Port number 0 to 3 |
| busWr | input | 1 | 1 = write, 0 = read |
| busWdata | input | 8 | Write byte |
| busRdata | output | 8 | Read byte (combinational) |
| clkRegAddr | output | 4 | Clock register number, low bits of the first-bank index |
| clkRegWe | output | 1 | Clock register write pulse |
| clkRegRd | output | 1 | Clock register read marker |
| clkRegWdata | output | 8 | Clock register write byte |
| clkRegRdata | input | 8 | Clock register read byte |

## Verification
The hardest case to reach is the boundary between the clock window and RAM in the first bank, together with the separation of the two banks when both hold the same index. The bench models a fourteen-entry clock register file on the register-side interface and sweeps every index of both banks with distinct arithmetic patterns, setting bit 7 on every other index write. It then rereads the first bank after the full second-bank sweep, and it counts clock strobes across each sweep so that a stray pulse from the wrong bank or range shows up.

// File: rtl/cmos_bank_port_pkg.sv
package cmos_bank_port_pkg;

  // Source of the read byte.
  typedef enum logic [1:0] {
    RD_ZERO = 2'd0,
    RD_CLK  = 2'd1,
    RD_RAM1 = 2'd2,
    RD_RAM2 = 2'd3
  } rdSel_e;

  // Strobes from control to datapath.
  typedef struct packed {
    logic   wrRam1;
    logic   wrRam2;
    rdSel_e rdSel;
  } nvStrobe_t;

  localparam logic [1:0] PORT_IDX1 = 2'd0;
  localparam logic [1:0] PORT_DAT1 = 2'd1;
  localparam logic [1:0] PORT_IDX2 = 2'd2;
  localparam logic [1:0] PORT_DAT2 = 2'd3;

endpackage

// File: rtl/cmos_bank_ctrl.sv
module cmos_bank_ctrl
  import cmos_bank_port_pkg::*;
#(
  parameter int IDX_W    = 7,
  parameter int CLK_REGS = 14,
  parameter int CLK_AW   = $clog2(CLK_REGS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busEn,
  input  logic [1:0]        busAddr,
  input  logic              busWr,
  input  logic [7:0]        busWdata,
  output logic [IDX_W-1:0]  idx1,
  output logic [IDX_W-1:0]  idx2,
  output nvStrobe_t         strobe,
  output logic [CLK_AW-1:0] clkRegAddr,
  output logic              clkRegWe,
  output logic              clkRegRd
);

  localparam logic [IDX_W-1:0] CLK_LIM = IDX_W'(CLK_REGS);

  logic inClk;
  logic wrAcc;
  logic rdAcc;

  assign inClk = (idx1 < CLK_LIM);
  assign wrAcc = busEn && busWr;
  assign rdAcc = busEn && !busWr;

  // Index latches: only the low IDX_W bits of the byte are kept.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      idx1 <= '0;
      idx2 <= '0;
    end else if (wrAcc) begin
      if (busAddr == PORT_IDX1) idx1 <= busWdata[IDX_W-1:0];
      if (busAddr == PORT_IDX2) idx2 <= busWdata[IDX_W-1:0];
    end
  end

  always_comb begin
    strobe        = '0;
    strobe.rdSel  = RD_ZERO;
    clkRegWe      = 1'b0;
    clkRegRd      = 1'b0;
    unique case (busAddr)
      PORT_DAT1: begin
        strobe.rdSel  = inClk ? RD_CLK : RD_RAM1;
        strobe.wrRam1 = wrAcc && !inClk;
        clkRegWe      = wrAcc && inClk;
        clkRegRd      = rdAcc && inClk;
      end
      PORT_DAT2: begin
        strobe.rdSel  = RD_RAM2;
        strobe.wrRam2 = wrAcc;
      end
      default: ;
    endcase
  end

  assign clkRegAddr = idx1[CLK_AW-1:0];

  assert_idx_load_R2: assert property (@(posedge clk) disable iff (!rstN)
    (busEn && busWr && busAddr == PORT_IDX1) |=> idx1 == $past(busWdata[IDX_W-1:0]));

  assert_idx_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    !(busEn && busWr && busAddr == PORT_IDX2) |=> $stable(idx2));

  assert_clk_range_R8: assert property (@(posedge clk) disable iff (!rstN)
    (clkRegWe || clkRegRd) |-> (busEn && busAddr == PORT_DAT1 && idx1 < CLK_LIM));

endmodule

// File: rtl/cmos_bank_dp.sv
module cmos_bank_dp
  import cmos_bank_port_pkg::*;
#(
  parameter int IDX_W    = 7,
  parameter int CLK_REGS = 14
) (
  input  logic             clk,
  input  logic             rstN,
  input  nvStrobe_t        strobe,
  input  logic [IDX_W-1:0] idx1,
  input  logic [IDX_W-1:0] idx2,
  input  logic [7:0]       wdata,
  input  logic [7:0]       clkRegRdata,
  output logic [7:0]       rdata
);

  localparam int DEPTH      = 1 << IDX_W;
  localparam int RAM1_DEPTH = DEPTH - CLK_REGS;

  logic [7:0]       ram1 [RAM1_DEPTH];
  logic [7:0]       ram2 [DEPTH];
  logic [IDX_W-1:0] ram1Addr;

  assign ram1Addr = idx1 - IDX_W'(CLK_REGS);

  // Storage is not reset: it models retained memory.
  always_ff @(posedge clk) begin
    if (strobe.wrRam1) ram1[ram1Addr] <= wdata;
    if (strobe.wrRam2) ram2[idx2]     <= wdata;
  end

  always_comb begin
    unique case (strobe.rdSel)
      RD_CLK:  rdata = clkRegRdata;
      RD_RAM1: rdata = ram1[ram1Addr];
      RD_RAM2: rdata = ram2[idx2];
      default: rdata = 8'h00;
    endcase
  end

  assert_ram1_range_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrRam1 |-> idx1 >= IDX_W'(CLK_REGS));

  assert_bank_excl_R5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.wrRam1, strobe.wrRam2}));

endmodule

// File: rtl/cmos_bank_port.sv
module cmos_bank_port
  import cmos_bank_port_pkg::*;
#(
  parameter int IDX_W    = 7,
  parameter int CLK_REGS = 14,
  parameter int CLK_AW   = $clog2(CLK_REGS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busEn,
  input  logic [1:0]        busAddr,
  input  logic              busWr,
  input  logic [7:0]        busWdata,
  output logic [7:0]        busRdata,
  output logic [CLK_AW-1:0] clkRegAddr,
  output logic              clkRegWe,
  output logic              clkRegRd,
  output logic [7:0]        clkRegWdata,
  input  logic [7:0]        clkRegRdata
);

  nvStrobe_t        strobe;
  logic [IDX_W-1:0] idx1;
  logic [IDX_W-1:0] idx2;

  cmos_bank_ctrl #(.IDX_W(IDX_W), .CLK_REGS(CLK_REGS), .CLK_AW(CLK_AW)) i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .busEn      (busEn),
    .busAddr    (busAddr),
    .busWr      (busWr),
    .busWdata   (busWdata),
    .idx1       (idx1),
    .idx2       (idx2),
    .strobe     (strobe),
    .clkRegAddr (clkRegAddr),
    .clkRegWe   (clkRegWe),
    .clkRegRd   (clkRegRd)
  );

  cmos_bank_dp #(.IDX_W(IDX_W), .CLK_REGS(CLK_REGS)) i_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .idx1        (idx1),
    .idx2        (idx2),
    .wdata       (busWdata),
    .clkRegRdata (clkRegRdata),
    .rdata       (busRdata)
  );

  assign clkRegWdata = busWdata;

  assert_idx_read_zero_R7: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr[0] == 1'b0) |-> busRdata == 8'h00);

  assert_clk_we_R3: assert property (@(posedge clk) disable iff (!rstN)
    clkRegWe |-> (busWr && clkRegWdata == busWdata));

endmodule

// File: tb/test_cmos_bank_port.sv
module test_cmos_bank_port;

  localparam int CLK_PERIOD = 10;
  localparam int CLK_REGS   = 14;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       busEn = 1'b0;
  logic [1:0] busAddr = 2'd0;
  logic       busWr = 1'b0;
  logic [7:0] busWdata = 8'h00;
  logic [7:0] busRdata;
  logic [3:0] clkRegAddr;
  logic       clkRegWe;
  logic       clkRegRd;
  logic [7:0] clkRegWdata;
  logic [7:0] clkRegRdata;

  int checks = 0;
  int failures = 0;
  int weCount = 0;
  int rdCount = 0;
  bit done = 1'b0;

  logic [7:0] clkModel [CLK_REGS];

  always #(CLK_PERIOD/2) clk = ~clk;

  cmos_bank_port i_cmos_bank_port (
    .clk(clk), .rstN(rstN), .busEn(busEn), .busAddr(busAddr), .busWr(busWr),
    .busWdata(busWdata), .busRdata(busRdata), .clkRegAddr(clkRegAddr),
    .clkRegWe(clkRegWe), .clkRegRd(clkRegRd), .clkRegWdata(clkRegWdata),
    .clkRegRdata(clkRegRdata)
  );

  // Bench model of the clock register file.
  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < CLK_REGS; i++) clkModel[i] <= 8'(8'h5A + i);
    end else begin
      if (clkRegWe && clkRegAddr < CLK_REGS) clkModel[clkRegAddr] <= clkRegWdata;
      if (clkRegWe) weCount <= weCount + 1;
      if (clkRegRd) rdCount <= rdCount + 1;
    end
  end
  assign clkRegRdata = (clkRegAddr < CLK_REGS) ? clkModel[clkRegAddr] : 8'hFF;

  function automatic logic [7:0] pat1(int a);
    return 8'((a * 37 + 11) ^ 8'h5A);
  endfunction
  function automatic logic [7:0] pat2(int a);
    return 8'(a * 13 + 200);
  endfunction

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic wrPort(input logic [1:0] p, input logic [7:0] d, input logic en);
    @(negedge clk);
    busEn = en; busAddr = p; busWr = 1'b1; busWdata = d;
    @(negedge clk);
    busEn = 1'b0; busWr = 1'b0;
  endtask

  task automatic rdPort(input logic [1:0] p, output logic [7:0] d);
    @(negedge clk);
    busEn = 1'b1; busAddr = p; busWr = 1'b0;
    #1 d = busRdata;
    @(negedge clk);
    busEn = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    int w0;
    int r0;
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // R1: reset index routes port 1 to clock register 0.
    rdPort(2'd1, d);
    chk(8'(clkRegAddr), 8'h00, "R1 clkRegAddr after reset");
    chk(d, 8'h5A, "R1 port1 read after reset");

    // Bank one sweep: write every index, odd indexes with bit 7 set (R2).
    w0 = weCount;
    for (int a = 0; a < 128; a++) begin
      wrPort(2'd0, 8'(a) | ((a % 2) ? 8'h80 : 8'h00), 1'b1);
      wrPort(2'd1, pat1(a), 1'b1);
    end
    chk(8'(weCount - w0), 8'(CLK_REGS), "R3 clock write pulse count");
    for (int a = 0; a < 128; a++) begin
      wrPort(2'd0, 8'(a) | ((a % 2) ? 8'h00 : 8'h80), 1'b1);
      rdPort(2'd1, d);
      if (a < CLK_REGS) chk(d, pat1(a), "R3 clock register readback");
      else              chk(d, pat1(a), "R4 bank one RAM readback");
    end
    for (int a = 0; a < CLK_REGS; a++)
      chk(clkModel[a], pat1(a), "R3 clock register content");

    // R8: clock read marker counts.
    r0 = rdCount;
    wrPort(2'd0, 8'h05, 1'b1);
    rdPort(2'd1, d);
    chk(8'(clkRegAddr), 8'h05, "R3 clkRegAddr follows index");
    rdPort(2'd1, d);
    wrPort(2'd0, 8'h0E, 1'b1);
    rdPort(2'd1, d);
    chk(8'(rdCount - r0), 8'd2, "R8 clock read marker count");

    // Bank two sweep (R5, R8).
    w0 = weCount; r0 = rdCount;
    for (int a = 0; a < 128; a++) begin
      wrPort(2'd2, 8'(a) | ((a % 2) ? 8'h80 : 8'h00), 1'b1);
      wrPort(2'd3, pat2(a), 1'b1);
    end
    for (int a = 0; a < 128; a++) begin
      wrPort(2'd2, 8'(a), 1'b1);
      rdPort(2'd3, d);
      chk(d, pat2(a), "R5 bank two readback");
    end
    chk(8'(weCount - w0), 8'd0, "R8 no clock write from bank two");
    chk(8'(rdCount - r0), 8'd0, "R8 no clock read from bank two");
    for (int a = CLK_REGS; a < 128; a++) begin
      wrPort(2'd0, 8'(a), 1'b1);
      rdPort(2'd1, d);
      chk(d, pat1(a), "R5 bank one intact after bank two");
    end
    for (int a = 0; a < CLK_REGS; a++)
      chk(clkModel[a], pat1(a), "R5 clock registers intact");

    // R6: index holds across repeated transfers.
    wrPort(2'd0, 8'h40, 1'b1);
    wrPort(2'd1, 8'h11, 1'b1);
    wrPort(2'd1, 8'h22, 1'b1);
    rdPort(2'd1, d);
    chk(d, 8'h22, "R6 repeated write same byte");
    rdPort(2'd1, d);
    chk(d, 8'h22, "R6 repeated read same byte");
    wrPort(2'd0, 8'h41, 1'b1);
    rdPort(2'd1, d);
    chk(d, pat1(8'h41), "R6 neighbour untouched");
    wrPort(2'd2, 8'h7F, 1'b1);
    wrPort(2'd3, 8'h33, 1'b1);
    wrPort(2'd3, 8'h44, 1'b1);
    rdPort(2'd3, d);
    chk(d, 8'h44, "R6 bank two repeated write");

    // R7: index ports read as zero.
    rdPort(2'd0, d);
    chk(d, 8'h00, "R7 port0 read");
    rdPort(2'd2, d);
    chk(d, 8'h00, "R7 port2 read");

    // R9: unstrobed writes do nothing.
    wrPort(2'd0, 8'h30, 1'b1);
    wrPort(2'd1, 8'hEE, 1'b0);
    rdPort(2'd1, d);
    chk(d, pat1(8'h30), "R9 unstrobed data write");
    wrPort(2'd0, 8'h50, 1'b0);
    rdPort(2'd1, d);
    chk(d, pat1(8'h30), "R9 unstrobed index write");
    wrPort(2'd0, 8'h03, 1'b1);
    w0 = weCount;
    wrPort(2'd1, 8'hEE, 1'b0);
    chk(8'(weCount - w0), 8'd0, "R9 no clock pulse unstrobed");
    chk(clkModel[3], pat1(3), "R9 clock register unchanged");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule